// File: doc/BRIEF.md
# Copy Engine Descriptor Ring Controller

This block keeps the bookkeeping for a pair of descriptor rings used by a copy engine. One ring carries outgoing work and the other carries receive buffers. Software posts entries by writing a new write index for a ring. A datapath stub consumes entries one at a time through a kick strobe. The block moves the matching read index forward, and for the outgoing ring it also keeps a software-completed index. All index arithmetic runs modulo a power-of-two ring size.

Every index change is evaluated against a high and a low occupancy threshold per ring. Updates that would overrun a ring, and receive lengths that exceed a programmed limit, raise sticky error flags. A halt command stops new work once any entry in flight has finished, and it reports completion through a readable status bit. A single interrupt line combines the enabled status bits.

Registers are 32-bit words selected by a 4-bit word address: 0 outgoing ring size, 1 receive ring size, 2 length limit, 3 command, 4 host enables, 5 host status, 6 error enables, 7 error status, 8 outgoing write index, 9 receive write index, 10 outgoing completed index, 11 outgoing read index (read only), 12 receive read index (read only), 13 outgoing thresholds, 14 receive thresholds. A write takes effect at the clock edge where `regWe` is high. Reads are combinational from `regAddr`.

Top module: `dring`

## Requirements
- R1: A size register (address 0 or 1) accepts a power of two from 2 to 2^IDX_W and reads back that entry count. Any other value is ignored. An accepted write sets that ring's indices to 0. Both sizes reset to 2^IDX_W.
- R2: Indices step as (idx+1) masked with (entries-1), so they wrap to 0. A kick accepted at one edge advances the read index at the following edge. A kick on an empty ring (read index equal to write index) is ignored.
- R3: The space left in a ring is (entries-1) minus the masked distance from the base index to the current write index. The base is the completed index for the outgoing ring and the read index for the receive ring. A write-index update that advances further than this space is ignored and sets error status bit 5 (outgoing) or bit 6 (receive). On the outgoing ring the distance from the completed index to the read index never exceeds the distance from the completed index to the write index.
- R4: A write to the completed index (address 10) is ignored if it would move past the outgoing read index.
- R5: On any index change of a ring, if the new occupancy (write index minus read index, masked) exceeds the high threshold (bits 15:0 of address 13 or 14), host status bit 1 (outgoing) or bit 3 (receive) sets.
- R6: On any index change, if the new occupancy is below the low threshold (bits 31:16 of the same register), host status bit 2 (outgoing) or bit 4 (receive) sets.
- R7: Host status bit 0 (copy complete) sets whenever either ring's read index advances.
- R8: Status bits are sticky. Writing 1 to a bit of address 5 or 7 clears it, and a new event in the same cycle wins over the clear.
- R9: `irq` is high when any host status bit (address 5) is set together with the same bit of address 4, or when any error status bit is set together with the same bit of address 6.
- R10: An accepted receive kick whose `dstLen` exceeds the limit in bits 15:0 of address 2 sets error status bit 7.
- R11: Command bit 0 requests a halt. While it is set, no kick is accepted. Command bit 3 reads 1 once no entry is in flight, and a kick accepted in the same cycle as the request still completes. Clearing bit 0 clears bit 3 at the next edge and resumes processing.
- R12: After reset all indices, status, enables and the command read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| srcKick | input | 1 | Datapath stub takes one outgoing entry |
| dstKick | input | 1 | Datapath stub fills one receive entry |
| dstLen | input | LEN_W | Byte count of the receive entry being filled |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A halt request can land in the same cycle that the datapath stub's kick is accepted. The kick must then finish and move the read index, and the halt status must rise only after that entry has drained. The bench provokes this by raising `srcKick` together with the command write in one cycle. It then reads back a read index advanced by exactly one and a command value showing both request and status. Further kicks made while halted must leave the read index unchanged.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int REG_AW   = 4;
  localparam int HOST_W   = 5;
  localparam int MISC_W   = 3;
  localparam int MISC_LSB = 5;
  localparam int CMD_STAT = 3;

  localparam logic [REG_AW-1:0] A_SRC_SIZE = 4'd0;
  localparam logic [REG_AW-1:0] A_DST_SIZE = 4'd1;
  localparam logic [REG_AW-1:0] A_MAXLEN   = 4'd2;
  localparam logic [REG_AW-1:0] A_CMD      = 4'd3;
  localparam logic [REG_AW-1:0] A_HOST_IE  = 4'd4;
  localparam logic [REG_AW-1:0] A_HOST_IS  = 4'd5;
  localparam logic [REG_AW-1:0] A_MISC_IE  = 4'd6;
  localparam logic [REG_AW-1:0] A_MISC_IS  = 4'd7;
  localparam logic [REG_AW-1:0] A_SRC_WR   = 4'd8;
  localparam logic [REG_AW-1:0] A_DST_WR   = 4'd9;
  localparam logic [REG_AW-1:0] A_SRC_DONE = 4'd10;
  localparam logic [REG_AW-1:0] A_SRC_RD   = 4'd11;
  localparam logic [REG_AW-1:0] A_DST_RD   = 4'd12;
  localparam logic [REG_AW-1:0] A_SRC_WM   = 4'd13;
  localparam logic [REG_AW-1:0] A_DST_WM   = 4'd14;

  // control -> datapath strobes
  typedef struct packed {
    logic srcClr;
    logic dstClr;
    logic srcWr;
    logic dstWr;
    logic doneWr;
    logic srcStep;
    logic dstStep;
  } ringStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic srcOvf;
    logic dstOvf;
    logic srcHi;
    logic srcLo;
    logic dstHi;
    logic dstLo;
    logic srcDone;
    logic dstDone;
  } ringEvent_t;
endpackage

// File: rtl/dring_track.sv
module dring_track #(
  parameter int IDX_W  = 8,
  parameter bit HAS_SW = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] mask,
  input  logic             clr,
  input  logic             wrReq,
  input  logic             swReq,
  input  logic             step,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [15:0]      loThr,
  input  logic [15:0]      hiThr,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] swIdx,
  output logic             notEmpty,
  output logic             ovfEv,
  output logic             hiEv,
  output logic             loEv,
  output logic             doneEv
);
  function automatic logic [IDX_W-1:0] gap(input logic [IDX_W-1:0] from,
                                           input logic [IDX_W-1:0] to,
                                           input logic [IDX_W-1:0] m);
    return (to - from) & m;
  endfunction

  logic [IDX_W-1:0] rdQ, wrQ, base, used, space, adv, tgt;
  logic [IDX_W-1:0] rdNext, wrNext, occNext;
  logic wrOk, swOk, moved;

  assign tgt = reqIdx & mask;

  generate
    if (HAS_SW) begin : g_sw
      logic [IDX_W-1:0] swQ;
      assign swOk = swReq && (gap(swQ, tgt, mask) <= gap(swQ, rdQ, mask));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     swQ <= '0;
        else if (clr)  swQ <= '0;
        else if (swOk) swQ <= tgt;
      end
      assign base  = swQ;
      assign swIdx = swQ;
    end else begin : g_nosw
      assign swOk  = 1'b0 & swReq;
      assign base  = rdQ;
      assign swIdx = rdQ;
    end
  endgenerate

  assign used     = gap(base, wrQ, mask);
  assign space    = mask - used;
  assign adv      = gap(wrQ, tgt, mask);
  assign wrOk     = wrReq && (adv <= space);
  assign notEmpty = (rdQ != wrQ);
  assign doneEv   = step && notEmpty && !clr;
  assign ovfEv    = wrReq && !wrOk;

  assign rdNext  = doneEv ? ((rdQ + 1'b1) & mask) : rdQ;
  assign wrNext  = wrOk ? tgt : wrQ;
  assign occNext = gap(rdNext, wrNext, mask);
  assign moved   = wrOk || doneEv;
  assign hiEv    = moved && (32'(occNext) > 32'(hiThr));
  assign loEv    = moved && (32'(occNext) < 32'(loThr));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
      wrQ <= '0;
    end else if (clr) begin
      rdQ <= '0;
      wrQ <= '0;
    end else begin
      rdQ <= rdNext;
      wrQ <= wrNext;
    end
  end

  assign rdIdx = rdQ;
  assign wrIdx = wrQ;
endmodule

// File: rtl/dring_path.sv
module dring_path
  import dring_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobe_t      stb,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [IDX_W-1:0] srcMask,
  input  logic [IDX_W-1:0] dstMask,
  input  logic [31:0]      srcWm,
  input  logic [31:0]      dstWm,
  output logic [IDX_W-1:0] srcRd,
  output logic [IDX_W-1:0] srcWr,
  output logic [IDX_W-1:0] srcSw,
  output logic [IDX_W-1:0] dstRd,
  output logic [IDX_W-1:0] dstWr,
  output logic [1:0]       notEmpty,
  output ringEvent_t       ev
);
  localparam int RINGS = 2;

  logic [IDX_W-1:0] maskA [RINGS];
  logic [IDX_W-1:0] rdA   [RINGS];
  logic [IDX_W-1:0] wrA   [RINGS];
  logic [IDX_W-1:0] swA   [RINGS];
  logic [31:0]      wmA   [RINGS];
  logic [RINGS-1:0] clrV, wrV, swV, stepV, ovfV, hiV, loV, doneV;

  assign maskA[0] = srcMask;
  assign maskA[1] = dstMask;
  assign wmA[0]   = srcWm;
  assign wmA[1]   = dstWm;
  assign clrV     = {stb.dstClr, stb.srcClr};
  assign wrV      = {stb.dstWr, stb.srcWr};
  assign swV      = {1'b0, stb.doneWr};
  assign stepV    = {stb.dstStep, stb.srcStep};

  generate
    for (genvar r = 0; r < RINGS; r++) begin : g_ring
      dring_track #(.IDX_W(IDX_W), .HAS_SW(r == 0)) u_trk (
        .clk      (clk),
        .rstN     (rstN),
        .mask     (maskA[r]),
        .clr      (clrV[r]),
        .wrReq    (wrV[r]),
        .swReq    (swV[r]),
        .step     (stepV[r]),
        .reqIdx   (reqIdx),
        .loThr    (wmA[r][31:16]),
        .hiThr    (wmA[r][15:0]),
        .rdIdx    (rdA[r]),
        .wrIdx    (wrA[r]),
        .swIdx    (swA[r]),
        .notEmpty (notEmpty[r]),
        .ovfEv    (ovfV[r]),
        .hiEv     (hiV[r]),
        .loEv     (loV[r]),
        .doneEv   (doneV[r])
      );
    end
  endgenerate

  assign srcRd = rdA[0];
  assign srcWr = wrA[0];
  assign srcSw = swA[0];
  assign dstRd = rdA[1];
  assign dstWr = wrA[1];

  assign ev.srcOvf  = ovfV[0];
  assign ev.dstOvf  = ovfV[1];
  assign ev.srcHi   = hiV[0];
  assign ev.srcLo   = loV[0];
  assign ev.dstHi   = hiV[1];
  assign ev.dstLo   = loV[1];
  assign ev.srcDone = doneV[0];
  assign ev.dstDone = doneV[1];
endmodule

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  logic              srcKick,
  input  logic              dstKick,
  input  logic [LEN_W-1:0]  dstLen,
  input  logic [1:0]        notEmpty,
  input  ringEvent_t        ev,
  input  logic [IDX_W-1:0]  srcRd,
  input  logic [IDX_W-1:0]  srcWr,
  input  logic [IDX_W-1:0]  srcSw,
  input  logic [IDX_W-1:0]  dstRd,
  input  logic [IDX_W-1:0]  dstWr,
  output ringStrobe_t       stb,
  output logic [IDX_W-1:0]  srcMask,
  output logic [IDX_W-1:0]  dstMask,
  output logic [31:0]       srcWm,
  output logic [31:0]       dstWm,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              haltReq,
  output logic              haltStat,
  output logic              busy,
  output logic [HOST_W-1:0] hostIs,
  output logic [MISC_W-1:0] miscIs
);
  function automatic logic sizeOk(input logic [31:0] v);
    return (v >= 32'd2) && (v <= (32'd1 << IDX_W)) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  logic [LEN_W-1:0]  maxLen;
  logic [HOST_W-1:0] hostIe, hostSet, hostClr;
  logic [MISC_W-1:0] miscIe, miscSet, miscClr;
  logic srcBusy, dstBusy, srcTake, dstTake, lenViol;

  function automatic logic hit(input logic [REG_AW-1:0] a);
    return regWe && (regAddr == a);
  endfunction

  // datapath stub acceptance: one entry in flight per ring
  assign srcTake = srcKick && !haltReq && !srcBusy && notEmpty[0];
  assign dstTake = dstKick && !haltReq && !dstBusy && notEmpty[1];
  assign lenViol = dstTake && (dstLen > maxLen);
  assign busy    = srcBusy || dstBusy;

  assign stb.srcClr  = hit(A_SRC_SIZE) && sizeOk(regWdata);
  assign stb.dstClr  = hit(A_DST_SIZE) && sizeOk(regWdata);
  assign stb.srcWr   = hit(A_SRC_WR);
  assign stb.dstWr   = hit(A_DST_WR);
  assign stb.doneWr  = hit(A_SRC_DONE);
  assign stb.srcStep = srcBusy;
  assign stb.dstStep = dstBusy;

  assign hostSet = {ev.dstLo, ev.dstHi, ev.srcLo, ev.srcHi, ev.srcDone | ev.dstDone};
  assign miscSet = {lenViol, ev.dstOvf, ev.srcOvf};
  assign hostClr = hit(A_HOST_IS) ? regWdata[HOST_W-1:0] : '0;
  assign miscClr = hit(A_MISC_IS) ? regWdata[MISC_LSB +: MISC_W] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcMask  <= '1;
      dstMask  <= '1;
      maxLen   <= '0;
      hostIe   <= '0;
      miscIe   <= '0;
      srcWm    <= '0;
      dstWm    <= '0;
      haltReq  <= 1'b0;
      haltStat <= 1'b0;
      srcBusy  <= 1'b0;
      dstBusy  <= 1'b0;
      hostIs   <= '0;
      miscIs   <= '0;
    end else begin
      if (stb.srcClr)    srcMask <= IDX_W'(regWdata - 32'd1);
      if (stb.dstClr)    dstMask <= IDX_W'(regWdata - 32'd1);
      if (hit(A_MAXLEN)) maxLen  <= regWdata[LEN_W-1:0];
      if (hit(A_HOST_IE)) hostIe <= regWdata[HOST_W-1:0];
      if (hit(A_MISC_IE)) miscIe <= regWdata[MISC_LSB +: MISC_W];
      if (hit(A_SRC_WM)) srcWm   <= regWdata;
      if (hit(A_DST_WM)) dstWm   <= regWdata;
      if (hit(A_CMD))    haltReq <= regWdata[0];
      haltStat <= haltReq && !srcBusy && !dstBusy;
      srcBusy  <= srcTake;
      dstBusy  <= dstTake;
      hostIs   <= (hostIs & ~hostClr) | hostSet;
      miscIs   <= (miscIs & ~miscClr) | miscSet;
    end
  end

  assign irq = (|(hostIs & hostIe)) || (|(miscIs & miscIe));

  always_comb begin
    case (regAddr)
      A_SRC_SIZE: regRdata = 32'(srcMask) + 32'd1;
      A_DST_SIZE: regRdata = 32'(dstMask) + 32'd1;
      A_MAXLEN:   regRdata = 32'(maxLen);
      A_CMD:      regRdata = 32'(haltReq) | (32'(haltStat) << CMD_STAT);
      A_HOST_IE:  regRdata = 32'(hostIe);
      A_HOST_IS:  regRdata = 32'(hostIs);
      A_MISC_IE:  regRdata = 32'(miscIe) << MISC_LSB;
      A_MISC_IS:  regRdata = 32'(miscIs) << MISC_LSB;
      A_SRC_WR:   regRdata = 32'(srcWr);
      A_DST_WR:   regRdata = 32'(dstWr);
      A_SRC_DONE: regRdata = 32'(srcSw);
      A_SRC_RD:   regRdata = 32'(srcRd);
      A_DST_RD:   regRdata = 32'(dstRd);
      A_SRC_WM:   regRdata = srcWm;
      A_DST_WM:   regRdata = dstWm;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dring.sv
module dring
  import dring_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             srcKick,
  input  logic             dstKick,
  input  logic [LEN_W-1:0] dstLen,
  output logic             irq
);
  ringStrobe_t      stb;
  ringEvent_t       ev;
  logic [IDX_W-1:0] srcMask, dstMask, srcRd, srcWr, srcSw, dstRd, dstWr;
  logic [31:0]      srcWm, dstWm;
  logic [1:0]       notEmpty;
  logic             haltReq, haltStat, busy, srcClr, dstClr;
  logic [HOST_W-1:0] hostIs;
  logic [MISC_W-1:0] miscIs;

  assign srcClr = stb.srcClr;
  assign dstClr = stb.dstClr;

  dring_regs #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_regs (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .srcKick, .dstKick, .dstLen,
    .notEmpty, .ev, .srcRd, .srcWr, .srcSw, .dstRd, .dstWr, .stb,
    .srcMask, .dstMask, .srcWm, .dstWm, .regRdata, .irq,
    .haltReq, .haltStat, .busy, .hostIs, .miscIs
  );

  dring_path #(.IDX_W(IDX_W)) u_path (
    .clk, .rstN, .stb, .reqIdx(regWdata[IDX_W-1:0]), .srcMask, .dstMask,
    .srcWm, .dstWm, .srcRd, .srcWr, .srcSw, .dstRd, .dstWr, .notEmpty, .ev
  );
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [3:0]       regAddr,
  input logic             irq,
  input logic [IDX_W-1:0] srcMask,
  input logic [IDX_W-1:0] srcRd,
  input logic [IDX_W-1:0] srcWr,
  input logic [IDX_W-1:0] srcSw,
  input logic [IDX_W-1:0] dstRd,
  input logic             srcClr,
  input logic             dstClr,
  input logic             haltReq,
  input logic             haltStat,
  input logic             busy,
  input logic [4:0]       hostIs,
  input logic [2:0]       miscIs
);
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((srcRd & ~srcMask) == '0) && ((srcWr & ~srcMask) == '0));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    !srcClr |=> (srcRd == $past(srcRd)) || (srcRd == (($past(srcRd) + 1'b1) & srcMask)));

  assert_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((srcRd - srcSw) & srcMask) <= ((srcWr - srcSw) & srcMask));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == 4'd5) |=> ((hostIs & $past(hostIs)) == $past(hostIs)));

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (hostIs != '0) || (miscIs != '0));

  assert_halt_rise_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltStat) |-> $past(haltReq) && !$past(busy));

  assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    (haltStat && !srcClr && !dstClr) |=> $stable(srcRd) && $stable(dstRd));
endmodule

bind dring dring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .irq(irq),
  .srcMask(srcMask), .srcRd(srcRd), .srcWr(srcWr), .srcSw(srcSw), .dstRd(dstRd),
  .srcClr(srcClr), .dstClr(dstClr), .haltReq(haltReq), .haltStat(haltStat),
  .busy(busy), .hostIs(hostIs), .miscIs(miscIs)
);

// File: tb/sim_dring.sv
module sim_dring;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_KS = 2'd1, OP_KD = 2'd2, OP_NOP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [15:0] len;
    logic [3:0]  chk;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd0, 32'd8, 16'd0, 4'd0, 32'd8, 4'd1},               // R1 size 8 accepted
    '{OP_WR, 4'd0, 32'd6, 16'd0, 4'd0, 32'd8, 4'd1},               // R1 size 6 ignored
    '{OP_WR, 4'd1, 32'd4, 16'd0, 4'd1, 32'd4, 4'd1},               // R1 receive size 4
    '{OP_WR, 4'd13, 32'h0001_0005, 16'd0, 4'd13, 32'h0001_0005, 4'd5}, // R5 thresholds
    '{OP_WR, 4'd14, 32'h0001_0002, 16'd0, 4'd14, 32'h0001_0002, 4'd6}, // R6 thresholds
    '{OP_WR, 4'd8, 32'd3, 16'd0, 4'd5, 32'd0, 4'd5},               // R5 occ 3 no flag
    '{OP_WR, 4'd8, 32'd7, 16'd0, 4'd5, 32'd2, 4'd5},               // R5 occ 7 > 5
    '{OP_WR, 4'd5, 32'd2, 16'd0, 4'd5, 32'd0, 4'd8},               // R8 write-one clear
    '{OP_WR, 4'd8, 32'd0, 16'd0, 4'd7, 32'h20, 4'd3},              // R3 overflow bit 5
    '{OP_NOP, 4'd0, 32'd0, 16'd0, 4'd8, 32'd7, 4'd3},              // R3 write ignored
    '{OP_KS, 4'd0, 32'd0, 16'd0, 4'd11, 32'd1, 4'd2},              // R2 read advances
    '{OP_NOP, 4'd0, 32'd0, 16'd0, 4'd5, 32'd3, 4'd7},              // R7 complete + hi
    '{OP_WR, 4'd10, 32'd2, 16'd0, 4'd10, 32'd0, 4'd4},             // R4 past read ignored
    '{OP_WR, 4'd10, 32'd1, 16'd0, 4'd10, 32'd1, 4'd4},             // R4 accepted
    '{OP_WR, 4'd8, 32'd0, 16'd0, 4'd8, 32'd0, 4'd2},               // R2 write wraps to 0
    '{OP_WR, 4'd5, 32'h1F, 16'd0, 4'd5, 32'd0, 4'd8},              // R8 clear host
    '{OP_WR, 4'd7, 32'h20, 16'd0, 4'd7, 32'd0, 4'd8},              // R8 clear error
    '{OP_WR, 4'd9, 32'd2, 16'd0, 4'd5, 32'd0, 4'd5},               // R5 occ 2 not above 2
    '{OP_WR, 4'd2, 32'd100, 16'd0, 4'd2, 32'd100, 4'd10},          // R10 limit
    '{OP_KD, 4'd0, 32'd0, 16'd200, 4'd7, 32'h80, 4'd10},           // R10 length violation
    '{OP_NOP, 4'd0, 32'd0, 16'd0, 4'd12, 32'd1, 4'd2},             // R2 receive read
    '{OP_NOP, 4'd0, 32'd0, 16'd0, 4'd5, 32'd1, 4'd7},              // R7 receive completion
    '{OP_KD, 4'd0, 32'd0, 16'd50, 4'd5, 32'h11, 4'd6},             // R6 occ 0 < 1
    '{OP_WR, 4'd9, 32'd1, 16'd0, 4'd5, 32'h19, 4'd5},              // R5 receive occ 3 > 2
    '{OP_WR, 4'd9, 32'd3, 16'd0, 4'd7, 32'hC0, 4'd3}               // R3 overflow bit 6
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic srcKick = 1'b0;
  logic dstKick = 1'b0;
  logic [15:0] dstLen = '0;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dring u0 (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .regRdata,
    .srcKick, .dstKick, .dstLen, .irq
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic kickSrc();
    @(negedge clk); srcKick = 1'b1;
    @(negedge clk); srcKick = 1'b0;
  endtask

  task automatic kickDst(input logic [15:0] len);
    @(negedge clk); dstKick = 1'b1; dstLen = len;
    @(negedge clk); dstKick = 1'b0;
  endtask

  task automatic readCheck(input logic [3:0] a, input logic [31:0] exp, input int rq);
    regAddr = a;
    #1;
    checks++;
    if (regRdata !== exp) begin
      errors++;
      $display("FAIL R%0d addr %0d actual 0x%08h expected 0x%08h", rq, a, regRdata, exp);
    end
  endtask

  task automatic irqCheck(input logic exp, input int rq);
    #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL R%0d irq actual %0b expected %0b", rq, irq, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R12 reset state, R1 reset size
    readCheck(4'd0, 32'd256, 1);
    readCheck(4'd5, 32'd0, 12);
    readCheck(4'd3, 32'd0, 12);
    readCheck(4'd11, 32'd0, 12);
    irqCheck(1'b0, 12);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   regWrite(VECS[i].addr, VECS[i].data);
        OP_KS:   kickSrc();
        OP_KD:   kickDst(VECS[i].len);
        default: ;
      endcase
      idle(2);
      readCheck(VECS[i].chk, VECS[i].exp, int'(VECS[i].rq));
    end

    // R9 interrupt masking
    irqCheck(1'b0, 9);
    regWrite(4'd6, 32'h40);
    irqCheck(1'b1, 9);
    regWrite(4'd6, 32'h0);
    regWrite(4'd4, 32'h1);
    irqCheck(1'b1, 9);
    regWrite(4'd4, 32'h0);
    irqCheck(1'b0, 9);

    // R11 halt request, status, frozen read index
    regWrite(4'd3, 32'd1);
    idle(2);
    readCheck(4'd3, 32'd9, 11);
    kickSrc();
    idle(2);
    readCheck(4'd11, 32'd1, 11);
    regWrite(4'd3, 32'd0);
    idle(2);
    readCheck(4'd3, 32'd0, 11);

    // R11 halt request in the same cycle as an accepted kick
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd3; regWdata = 32'd1; srcKick = 1'b1;
    @(negedge clk);
    regWe = 1'b0; srcKick = 1'b0;
    idle(3);
    readCheck(4'd11, 32'd2, 11);
    readCheck(4'd3, 32'd9, 11);
    regWrite(4'd3, 32'd0);
    idle(2);

    // R2 read index wraps to 0, then kick on empty ring ignored
    for (int k = 0; k < 6; k++) begin
      kickSrc();
      idle(1);
    end
    idle(1);
    readCheck(4'd11, 32'd0, 2);
    kickSrc();
    idle(2);
    readCheck(4'd11, 32'd0, 2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule